// File: doc/BRIEF.md
# Hotplug Slot Status Register File

This block holds the pending hot-insert and pending hot-remove state for 32 slots on each of several buses. Host software reaches it through a small window of 32-bit registers. A bus-select register picks which bus the other registers refer to. Through the window the host reads that bus's insert, remove and removable masks, writes an eject request for one slot, and asks for the index value of one slot. That query is a write followed by a read.

A device model drives side-band inputs. A plug event sets a slot's insert bit and an unplug request sets its remove bit; each accepted event also produces a one-cycle event pulse. An eject, whether written by the host or issued during reset initialisation, clears the slot's insert and remove bits and emits a one-cycle detach request naming the bus and slot. The slot-index table is kept outside the block. The block presents the queried bus and slot on output ports and samples the returned value.

Reset initialisation runs after power-on reset and after every warm-reset pulse. It visits the buses one at a time. On each bus it ejects every pending remove, then loads the removable mask with ones everywhere except the slots marked non-hotpluggable. A legacy mode keeps insert bits after they are read and pins the bus select to bus 0.

Top module: `hp_slot_regs`

## Requirements
- R1: Register offsets with full-word access: 0x00 is the insert mask, 0x04 the remove mask, 0x08 eject (reads always return zero), 0x0C the removable mask, 0x10 bus select and 0x14 slot-index query. Each read returns the value for the selected bus in the same cycle.
- R2: An access is accepted only when reg_be is 4'hF, reg_addr[1:0] is 0 and the offset is below 0x18. Any other access reads zero and changes no state.
- R3: Outside legacy mode, reading the insert register clears the selected bus's insert mask. In legacy mode the mask is kept.
- R4: While the select value is NUM_BUS or higher, every register read returns zero, and eject or index-query writes have no effect. The select register itself can still be written.
- R5: An eject write uses the lowest set bit of the data as the slot number. It clears that slot's insert and remove bits on the selected bus, and on the next cycle detach_pulse is high for one cycle with detach_bus and detach_slot set. Data of zero does nothing.
- R6: A write to bus select stores all 32 data bits. In legacy mode the stored value is 0 instead.
- R7: Every accepted register write first clears the latched index. An index write latches idxq_value for the lowest set bit of the data, which appears on idxq_slot with idxq_bus = the selected bus. The next index read returns the latched value and clears it.
- R8: A plug event on a bus below NUM_BUS with plug_index ≤ 16383 sets the slot's insert bit and pulses event_pulse on the next cycle. A plug event with a larger index is rejected: no bit is set and no event is raised.
- R9: An unplug request sets the slot's remove bit and pulses event_pulse. Reading the remove mask does not clear it.
- R10: After rst_n or a warm_rst pulse, the buses are visited in order 0 to NUM_BUS-1, one eject per cycle. On each bus, pending removes are ejected lowest slot first and each produces a detach pulse. The removable mask of that bus is then set to ~nohp_mask slice. Register accesses are ignored during the walk, and bus select and the index latch return to 0.
- R11: When an event sets a bit in the same cycle that a read or eject clears the mask, the newly set bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warm_rst | input | 1 | One-cycle request to rerun reset initialisation |
| legacy_mode | input | 1 | Legacy behaviour for insert reads and bus select |
| nohp_mask | input | NUM_BUS*32 | Non-hotpluggable slot flags, 32 bits per bus, bus 0 in the low word |
| reg_req | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset within the window |
| reg_be | input | 4 | Byte enables, little-endian lanes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| plug_valid | input | 1 | Plug event strobe |
| plug_bus | input | BUS_W | Bus of the plug event |
| plug_slot | input | 5 | Slot of the plug event |
| plug_index | input | 32 | Index value that comes with the plug event |
| unplug_valid | input | 1 | Unplug request strobe |
| unplug_bus | input | BUS_W | Bus of the unplug request |
| unplug_slot | input | 5 | Slot of the unplug request |
| event_pulse | output | 1 | One-cycle event interrupt pulse |
| detach_pulse | output | 1 | One-cycle detach request |
| detach_bus | output | BUS_W | Bus to detach on |
| detach_slot | output | 5 | Slot to detach |
| idxq_bus | output | BUS_W | Bus of the index lookup |
| idxq_slot | output | 5 | Slot of the index lookup |
| idxq_value | input | 32 | Index value returned by the external table |

## Verification
Wrong bank state shows only through a register read. A bad insert or remove bit is therefore seen at reg_rdata in the same cycle as the first read of that bus. A clear that fails to happen shows up on the second read. Sequencing faults in the reset walk or in eject decoding appear one cycle after the cause, on detach_pulse, detach_bus and detach_slot. The order of the detach pulses across several buses exposes a wrong bus counter or a wrong priority. A stale or wrongly cleared index latch appears on the index read that immediately follows the query write.

// File: rtl/hp_regs_pkg.sv
package hp_regs_pkg;

   localparam int WIN_BYTES = 24;

   typedef enum logic [2:0] {
      RID_INS  = 3'd0,
      RID_REM  = 3'd1,
      RID_EJ   = 3'd2,
      RID_RMV  = 3'd3,
      RID_SEL  = 3'd4,
      RID_IDX  = 3'd5,
      RID_NONE = 3'd7
   } reg_id_e;

   // Full-word, aligned, in-window accesses only.
   function automatic reg_id_e decode_reg(input logic [4:0] addr, input logic [3:0] be);
      reg_id_e r;
      r = RID_NONE;
      if (be == 4'hF && addr[1:0] == 2'b00 && int'(addr) < WIN_BYTES) begin
         case (addr[4:2])
            3'd0:    r = RID_INS;
            3'd1:    r = RID_REM;
            3'd2:    r = RID_EJ;
            3'd3:    r = RID_RMV;
            3'd4:    r = RID_SEL;
            3'd5:    r = RID_IDX;
            default: r = RID_NONE;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/hp_lsb_find.sv
module hp_lsb_find #(
   parameter int W  = 32,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          found
);
   always_comb begin
      idx   = '0;
      found = |vec;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/hp_bus_bank.sv
module hp_bus_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ins_set,
   input  logic [W-1:0] ins_clr,
   input  logic [W-1:0] rem_set,
   input  logic [W-1:0] rem_clr,
   input  logic         rmv_load,
   input  logic [W-1:0] rmv_val,
   output logic [W-1:0] ins_q,
   output logic [W-1:0] rem_q,
   output logic [W-1:0] rmv_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ins_q <= '0;
         rem_q <= '0;
         rmv_q <= '0;
      end else begin
         ins_q <= (ins_q & ~ins_clr) | ins_set;
         rem_q <= (rem_q & ~rem_clr) | rem_set;
         if (rmv_load) rmv_q <= rmv_val;
      end
   end

   // A set in the same cycle as a clear must survive.
   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_set != '0) |=> ((ins_q & $past(ins_set)) == $past(ins_set)));
   assert_rem_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_set != '0) |=> ((rem_q & $past(rem_set)) == $past(rem_set)));
endmodule

// File: rtl/hp_init_walk.sv
module hp_init_walk #(
   parameter int NUM_BUS = 4,
   parameter int W       = 32,
   parameter int BUS_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
   parameter int SLOT_W  = $clog2(W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [NUM_BUS*W-1:0] rem_flat,
   output logic                 busy,
   output logic [BUS_W-1:0]     bus,
   output logic                 ej_valid,
   output logic [SLOT_W-1:0]    ej_slot,
   output logic                 load
);
   localparam logic [BUS_W-1:0] LAST_BUS = BUS_W'(NUM_BUS - 1);

   logic [W-1:0] cur_rem;
   logic         pend;

   assign cur_rem = rem_flat[int'(bus)*W +: W];

   hp_lsb_find #(.W(W), .IW(SLOT_W)) u_pick (
      .vec  (cur_rem),
      .idx  (ej_slot),
      .found(pend)
   );

   assign ej_valid = busy && pend && !start;
   assign load     = busy && !pend && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         bus  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         bus  <= '0;
      end else if (load) begin
         if (bus == LAST_BUS) busy <= 1'b0;
         else                 bus  <= bus + 1'b1;
      end
   end

   // The walk ends only after the last bus had its removable mask loaded.
   assert_walk_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(load) && $past(bus) == LAST_BUS));
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
   import hp_regs_pkg::*;
#(
   parameter int NUM_BUS   = 4,
   parameter int DATA_W    = 32,
   parameter int INDEX_MAX = 16383,
   parameter int BUS_W     = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
   parameter int SLOT_W    = $clog2(DATA_W)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      warm_rst,
   input  logic                      legacy_mode,
   input  logic [NUM_BUS*DATA_W-1:0] nohp_mask,
   input  logic                      reg_req,
   input  logic                      reg_wr,
   input  logic [4:0]                reg_addr,
   input  logic [3:0]                reg_be,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   input  logic                      plug_valid,
   input  logic [BUS_W-1:0]          plug_bus,
   input  logic [SLOT_W-1:0]         plug_slot,
   input  logic [31:0]               plug_index,
   input  logic                      unplug_valid,
   input  logic [BUS_W-1:0]          unplug_bus,
   input  logic [SLOT_W-1:0]         unplug_slot,
   output logic                      event_pulse,
   output logic                      detach_pulse,
   output logic [BUS_W-1:0]          detach_bus,
   output logic [SLOT_W-1:0]         detach_slot,
   output logic [BUS_W-1:0]          idxq_bus,
   output logic [SLOT_W-1:0]         idxq_slot,
   input  logic [DATA_W-1:0]         idxq_value
);
   localparam int FLAT_W = NUM_BUS * DATA_W;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("hp_slot_regs: DATA_W must be 32");
      end
      if (NUM_BUS < 1 || NUM_BUS > (1 << BUS_W)) begin : g_bad_bus
         $error("hp_slot_regs: NUM_BUS out of range for BUS_W");
      end
   endgenerate

   logic [DATA_W-1:0] sel_q;
   logic [DATA_W-1:0] idx_q;
   logic              sel_ok;
   logic [BUS_W-1:0]  cur_bus;
   reg_id_e           rid;
   logic              rd_hit, wr_hit;
   logic [SLOT_W-1:0] wd_slot;
   logic              wd_found;

   logic [FLAT_W-1:0] ins_flat, rem_flat, rmv_flat;

   logic              walk_busy, walk_ej, walk_load;
   logic [BUS_W-1:0]  walk_bus;
   logic [SLOT_W-1:0] walk_slot;

   logic              clr_ins_rd, reg_ej, ej_any;
   logic [BUS_W-1:0]  ej_bus;
   logic [SLOT_W-1:0] ej_slot;
   logic              plug_ok, unplug_ok;

   // Access decode
   assign sel_ok  = (sel_q < DATA_W'(NUM_BUS));
   assign cur_bus = sel_ok ? sel_q[BUS_W-1:0] : '0;
   assign rid     = (reg_req && !walk_busy && !warm_rst) ? decode_reg(reg_addr, reg_be) : RID_NONE;
   assign rd_hit  = (rid != RID_NONE) && !reg_wr;
   assign wr_hit  = (rid != RID_NONE) && reg_wr;

   hp_lsb_find #(.W(DATA_W), .IW(SLOT_W)) u_wd_lsb (
      .vec  (reg_wdata),
      .idx  (wd_slot),
      .found(wd_found)
   );

   assign idxq_bus  = cur_bus;
   assign idxq_slot = wd_slot;

   // Read mux
   always_comb begin
      reg_rdata = '0;
      if (rd_hit && sel_ok) begin
         case (rid)
            RID_INS: reg_rdata = ins_flat[int'(cur_bus)*DATA_W +: DATA_W];
            RID_REM: reg_rdata = rem_flat[int'(cur_bus)*DATA_W +: DATA_W];
            RID_RMV: reg_rdata = rmv_flat[int'(cur_bus)*DATA_W +: DATA_W];
            RID_SEL: reg_rdata = sel_q;
            RID_IDX: reg_rdata = idx_q;
            default: reg_rdata = '0;
         endcase
      end
   end

   // Event and eject control
   assign clr_ins_rd = rd_hit && (rid == RID_INS) && sel_ok && !legacy_mode;
   assign reg_ej     = wr_hit && (rid == RID_EJ) && sel_ok && wd_found;
   assign ej_any     = reg_ej || walk_ej;
   assign ej_bus     = walk_ej ? walk_bus  : cur_bus;
   assign ej_slot    = walk_ej ? walk_slot : wd_slot;
   assign plug_ok    = plug_valid && (int'(plug_bus) < NUM_BUS) && (plug_index <= 32'(INDEX_MAX));
   assign unplug_ok  = unplug_valid && (int'(unplug_bus) < NUM_BUS);

   hp_init_walk #(.NUM_BUS(NUM_BUS), .W(DATA_W), .BUS_W(BUS_W), .SLOT_W(SLOT_W)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (warm_rst),
      .rem_flat(rem_flat),
      .busy    (walk_busy),
      .bus     (walk_bus),
      .ej_valid(walk_ej),
      .ej_slot (walk_slot),
      .load    (walk_load)
   );

   // One bank per bus
   generate
      for (genvar b = 0; b < NUM_BUS; b++) begin : g_bank
         logic [DATA_W-1:0] ej_mask, ins_clr, ins_set, rem_set;
         logic              here_ej, here_rd, here_load;

         assign here_ej   = ej_any && (int'(ej_bus) == b);
         assign here_rd   = clr_ins_rd && (int'(cur_bus) == b);
         assign here_load = walk_load && (int'(walk_bus) == b);
         assign ej_mask   = here_ej ? (DATA_W'(1) << ej_slot) : '0;
         assign ins_clr   = ej_mask | (here_rd ? '1 : '0);
         assign ins_set   = (plug_ok && int'(plug_bus) == b) ? (DATA_W'(1) << plug_slot) : '0;
         assign rem_set   = (unplug_ok && int'(unplug_bus) == b) ? (DATA_W'(1) << unplug_slot) : '0;

         hp_bus_bank #(.W(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .ins_set (ins_set),
            .ins_clr (ins_clr),
            .rem_set (rem_set),
            .rem_clr (ej_mask),
            .rmv_load(here_load),
            .rmv_val (~nohp_mask[b*DATA_W +: DATA_W]),
            .ins_q   (ins_flat[b*DATA_W +: DATA_W]),
            .rem_q   (rem_flat[b*DATA_W +: DATA_W]),
            .rmv_q   (rmv_flat[b*DATA_W +: DATA_W])
         );
      end
   endgenerate

   // Select, index latch and output pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q        <= '0;
         idx_q        <= '0;
         event_pulse  <= 1'b0;
         detach_pulse <= 1'b0;
         detach_bus   <= '0;
         detach_slot  <= '0;
      end else begin
         event_pulse  <= plug_ok || unplug_ok;
         detach_pulse <= ej_any;
         if (ej_any) begin
            detach_bus  <= ej_bus;
            detach_slot <= ej_slot;
         end
         if (warm_rst) begin
            sel_q <= '0;
            idx_q <= '0;
         end else if (wr_hit) begin
            if (rid == RID_SEL) sel_q <= legacy_mode ? '0 : reg_wdata;
            if (rid == RID_IDX && sel_ok && wd_found) idx_q <= idxq_value;
            else                                      idx_q <= '0;
         end else if (rd_hit && rid == RID_IDX && sel_ok) begin
            idx_q <= '0;
         end
      end
   end

   logic det_rem_bit;
   assign det_rem_bit = rem_flat[int'(detach_bus)*DATA_W + int'(detach_slot)];

   assert_evt_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      event_pulse |-> $past(plug_valid || unplug_valid));
   assert_reject_big_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (plug_valid && plug_index > 32'(INDEX_MAX) && !unplug_valid) |=> !event_pulse);
   assert_eject_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (detach_pulse && !$past(unplug_valid)) |-> !det_rem_bit);
   assert_idx_wipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_hit && rid != RID_IDX && !warm_rst) |-> (idx_q == '0));
   assert_legacy_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_hit && rid == RID_SEL && legacy_mode) |-> (sel_q == '0));
   assert_walk_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      walk_busy |-> (reg_rdata == '0 && !reg_ej));
   assert_outrange_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |-> (reg_rdata == '0));
endmodule

// File: tb/sim_hp_slot_regs.sv
`timescale 1ns/100ps
module sim_hp_slot_regs;
   localparam int NB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        warm_rst = 1'b0;
   logic        legacy_mode = 1'b0;
   logic [NB*32-1:0] nohp_mask;
   logic        reg_req = 1'b0, reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        plug_valid = 1'b0;
   logic [1:0]  plug_bus = '0;
   logic [4:0]  plug_slot = '0;
   logic [31:0] plug_index = '0;
   logic        unplug_valid = 1'b0;
   logic [1:0]  unplug_bus = '0;
   logic [4:0]  unplug_slot = '0;
   logic        event_pulse, detach_pulse;
   logic [1:0]  detach_bus, idxq_bus;
   logic [4:0]  detach_slot, idxq_slot;
   logic [31:0] idxq_value;

   int n_chk = 0, n_fail = 0;
   int evt_n = 0, det_n = 0;
   logic [1:0] det_bus_log [16];
   logic [4:0] det_slot_log [16];

   assign nohp_mask  = {32'hFFFF_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_0001};
   assign idxq_value = 32'h100 + {25'd0, idxq_bus, idxq_slot};

   always #2.5 clk = ~clk;

   hp_slot_regs #(.NUM_BUS(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .legacy_mode(legacy_mode),
      .nohp_mask(nohp_mask), .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .plug_valid(plug_valid), .plug_bus(plug_bus), .plug_slot(plug_slot),
      .plug_index(plug_index), .unplug_valid(unplug_valid), .unplug_bus(unplug_bus),
      .unplug_slot(unplug_slot), .event_pulse(event_pulse), .detach_pulse(detach_pulse),
      .detach_bus(detach_bus), .detach_slot(detach_slot), .idxq_bus(idxq_bus),
      .idxq_slot(idxq_slot), .idxq_value(idxq_value)
   );

   always @(negedge clk) begin
      if (event_pulse) evt_n++;
      if (detach_pulse) begin
         if (det_n < 16) begin
            det_bus_log[det_n]  = detach_bus;
            det_slot_log[det_n] = detach_slot;
         end
         det_n++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
      @(negedge clk);
      reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_be = be;
      #1 d = reg_rdata;
      @(posedge clk); #0.5;
      reg_req = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] v, input logic [3:0] be = 4'hF);
      @(negedge clk);
      reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = v;
      @(posedge clk); #0.5;
      reg_req = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic plug(input logic [1:0] b, input logic [4:0] s, input logic [31:0] ix, input bit accept);
      int e0;
      e0 = evt_n;
      @(negedge clk);
      plug_valid = 1'b1; plug_bus = b; plug_slot = s; plug_index = ix;
      @(posedge clk); #0.5;
      plug_valid = 1'b0;
      @(negedge clk); #1;
      chk("R8 event count after plug", 32'(evt_n - e0), accept ? 32'd1 : 32'd0);
   endtask

   task automatic unplug(input logic [1:0] b, input logic [4:0] s);
      int e0;
      e0 = evt_n;
      @(negedge clk);
      unplug_valid = 1'b1; unplug_bus = b; unplug_slot = s;
      @(posedge clk); #0.5;
      unplug_valid = 1'b0;
      @(negedge clk); #1;
      chk("R9 event count after unplug", 32'(evt_n - e0), 32'd1);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(5'h0C, d); chk("R10 bus0 removable after reset", d, 32'hFFFF_FFFE);
      rd(5'h10, d); chk("R1 select after reset", d, 32'h0);
      rd(5'h00, d); chk("R1 insert after reset", d, 32'h0);
      rd(5'h08, d); chk("R1 eject reads zero", d, 32'h0);
      wr(5'h10, 32'd3);
      rd(5'h0C, d); chk("R10 bus3 removable after reset", d, 32'h0000_FFFF);
   endtask

   task automatic t_plug();
      logic [31:0] d;
      wr(5'h10, 32'd0);
      plug(2'd0, 5'd5, 32'd16383, 1'b1);
      rd(5'h00, d); chk("R3 insert read returns bit", d, 32'h20);
      rd(5'h00, d); chk("R3 insert cleared by read", d, 32'h0);
      plug(2'd0, 5'd7, 32'd16384, 1'b0);
      rd(5'h00, d); chk("R8 oversized index rejected", d, 32'h0);
   endtask

   task automatic t_eject();
      int d0;
      logic [31:0] d;
      unplug(2'd2, 5'd3);
      unplug(2'd2, 5'd9);
      plug(2'd2, 5'd3, 32'd1, 1'b1);
      wr(5'h10, 32'd2);
      rd(5'h04, d); chk("R9 remove mask", d, 32'h208);
      rd(5'h04, d); chk("R9 remove mask not cleared by read", d, 32'h208);
      d0 = det_n;
      wr(5'h08, 32'h208);
      @(negedge clk); #1;
      chk("R5 one detach pulse", 32'(det_n - d0), 32'd1);
      chk("R5 detach bus", 32'(det_bus_log[d0]), 32'd2);
      chk("R5 detach slot is lowest set bit", 32'(det_slot_log[d0]), 32'd3);
      rd(5'h04, d); chk("R5 remove bit cleared", d, 32'h200);
      rd(5'h00, d); chk("R5 insert bit cleared", d, 32'h0);
      d0 = det_n;
      wr(5'h08, 32'h0);
      @(negedge clk); #1;
      chk("R5 zero data no detach", 32'(det_n - d0), 32'd0);
   endtask

   task automatic t_outrange();
      int d0;
      logic [31:0] d;
      wr(5'h10, 32'd7);
      rd(5'h10, d); chk("R4 select read zero out of range", d, 32'h0);
      rd(5'h04, d); chk("R4 remove read zero out of range", d, 32'h0);
      d0 = det_n;
      wr(5'h08, 32'h200);
      @(negedge clk); #1;
      chk("R4 eject ignored", 32'(det_n - d0), 32'd0);
      wr(5'h10, 32'd2);
      rd(5'h10, d); chk("R6 select stored", d, 32'd2);
      rd(5'h04, d); chk("R4 remove kept after ignored eject", d, 32'h200);
   endtask

   task automatic t_index();
      logic [31:0] d;
      wr(5'h14, 32'h30);
      rd(5'h14, d); chk("R7 index latched for slot 4", d, 32'h144);
      rd(5'h14, d); chk("R7 index cleared by read", d, 32'h0);
      wr(5'h14, 32'h30);
      wr(5'h10, 32'd2);
      rd(5'h14, d); chk("R7 other write clears index", d, 32'h0);
      wr(5'h14, 32'h0);
      rd(5'h14, d); chk("R7 zero data gives zero", d, 32'h0);
   endtask

   task automatic t_access();
      logic [31:0] d;
      rd(5'h04, d, 4'h3); chk("R2 partial read zero", d, 32'h0);
      rd(5'h06, d);       chk("R2 misaligned read zero", d, 32'h0);
      rd(5'h18, d);       chk("R2 out of window read zero", d, 32'h0);
      wr(5'h10, 32'd1, 4'h1);
      rd(5'h10, d);       chk("R2 partial write ignored", d, 32'd2);
   endtask

   task automatic t_same_cycle();
      logic [31:0] d;
      wr(5'h10, 32'd0);
      plug(2'd0, 5'd2, 32'd0, 1'b1);
      @(negedge clk);
      reg_req = 1'b1; reg_wr = 1'b0; reg_addr = 5'h00; reg_be = 4'hF;
      plug_valid = 1'b1; plug_bus = 2'd0; plug_slot = 5'd6; plug_index = 32'd0;
      #1 d = reg_rdata;
      @(posedge clk); #0.5;
      reg_req = 1'b0; plug_valid = 1'b0;
      chk("R11 read returns old mask", d, 32'h4);
      rd(5'h00, d); chk("R11 new bit survives clear", d, 32'h40);
   endtask

   task automatic t_warm();
      logic [31:0] d;
      int d0;
      unplug(2'd1, 5'd4);
      unplug(2'd1, 5'd0);
      unplug(2'd3, 5'd31);
      plug(2'd1, 5'd4, 32'd9, 1'b1);
      d0 = det_n;
      @(negedge clk); warm_rst = 1'b1;
      @(posedge clk); #0.5; warm_rst = 1'b0;
      repeat (14) @(posedge clk);
      @(negedge clk); #1;
      chk("R10 detach count in walk", 32'(det_n - d0), 32'd4);
      chk("R10 walk 1st", {det_bus_log[d0], det_slot_log[d0]}, {2'd1, 5'd0});
      chk("R10 walk 2nd", {det_bus_log[d0+1], det_slot_log[d0+1]}, {2'd1, 5'd4});
      chk("R10 walk 3rd", {det_bus_log[d0+2], det_slot_log[d0+2]}, {2'd2, 5'd9});
      chk("R10 walk 4th", {det_bus_log[d0+3], det_slot_log[d0+3]}, {2'd3, 5'd31});
      rd(5'h10, d); chk("R10 select reset", d, 32'h0);
      wr(5'h10, 32'd1);
      rd(5'h04, d); chk("R10 bus1 removes executed", d, 32'h0);
      rd(5'h00, d); chk("R10 bus1 insert cleared by eject", d, 32'h0);
      rd(5'h0C, d); chk("R10 bus1 removable", d, 32'h7FFF_FFFF);
   endtask

   task automatic t_legacy();
      logic [31:0] d;
      wr(5'h10, 32'd0);
      legacy_mode = 1'b1;
      plug(2'd0, 5'd1, 32'd0, 1'b1);
      rd(5'h00, d); chk("R3 legacy insert read", d, 32'h2);
      rd(5'h00, d); chk("R3 legacy insert kept", d, 32'h2);
      wr(5'h10, 32'd3);
      rd(5'h10, d); chk("R6 legacy select forced 0", d, 32'h0);
      legacy_mode = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1'b1;
      repeat (8) @(posedge clk);
      t_reset();
      t_plug();
      t_eject();
      t_outrange();
      t_index();
      t_access();
      t_same_cycle();
      t_warm();
      t_legacy();
      repeat (4) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule